// File: doc/BRIEF.md
# Bus Voltage Select Sequencer

This block moves a card bus between 3.3 V and 1.8 V signalling levels. A request names a target level. The block first checks the target against two capability inputs. If the target is supported, it writes a 3-bit level code. In a later cycle it asserts bus power. It then polls a power-good readback until that readback goes high or a bounded wait runs out.

On success the block raises or clears the low-voltage signalling enable to match the new level. Each request ends with exactly one outcome: a one-cycle pulse on done, unsupported or timeout. The analog supplies are outside the block; the power-good input stands in for them.

The wait bound is set from the clock frequency and a time in microseconds. The defaults give 1 ms at 50 MHz.

Top module: `bus_volt_seq`

## Requirements
- R1: An accepted 3.3 V request (req_volt = 2'b00) drives vsel to 3'b111. An accepted 1.8 V request (req_volt = 2'b01) drives vsel to 3'b101. The code 3'b110, for 3.0 V, is never driven because 3.0 V cannot be requested.
- R2: A 3.3 V request with cap_3v3 low, or a 1.8 V request with cap_1v8 low, gives an unsupported pulse in the cycle after the request. vsel, bus_pwr and lv_sig_en are left unchanged.
- R3: A request for req_volt = 2'b10 or 2'b11 is unsupported whatever the capability inputs are. It is handled the same way as in R2.
- R4: After an accepted request, vsel shows the new code one cycle later with bus_pwr low. bus_pwr goes high one cycle after that.
- R5: pwr_good is first sampled at the second clock edge after the request edge. done pulses in the cycle after the first edge at which pwr_good is seen high.
- R6: lv_sig_en changes only together with done. It becomes 1 after a completed 1.8 V switch and 0 after a completed 3.3 V switch.
- R7: If pwr_good is low at TMO consecutive poll edges (TMO = CLK_HZ/1e6 * TIMEOUT_US), timeout pulses TMO+2 cycles after the request edge. pwr_good seen high at the last poll edge still gives done. lv_sig_en is unchanged by a timeout. The wait counter is reloaded for every request.
- R8: A request that arrives while busy is high is ignored. busy is high from the cycle after acceptance until the outcome pulse.
- R9: After reset, vsel, bus_pwr, lv_sig_en, busy, done, unsupported and timeout are all 0.
- R10: done, unsupported and timeout are each one cycle wide. At most one of them is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, one cycle |
| req_volt | input | 2 | Target level: 00 = 3.3 V, 01 = 1.8 V, others reserved |
| cap_3v3 | input | 1 | 3.3 V is supported |
| cap_1v8 | input | 1 | 1.8 V is supported |
| pwr_good | input | 1 | Bus power readback |
| vsel | output | 3 | Level-select code |
| bus_pwr | output | 1 | Bus power enable |
| lv_sig_en | output | 1 | Low-voltage signalling enable |
| busy | output | 1 | A switch is in progress |
| done | output | 1 | Switch completed (pulse) |
| unsupported | output | 1 | Request refused (pulse) |
| timeout | output | 1 | Power-good wait expired (pulse) |

## Verification
Counting from the edge that takes the request, the results fall due as follows:
- unsupported appears one cycle later.
- The new vsel appears one cycle later, and bus_pwr one cycle after that.
- done appears one cycle after the first poll edge at which pwr_good is high. That edge is never earlier than the second edge.
- timeout appears TMO+2 cycles later.

Inputs are driven on falling edges and outputs are sampled on falling edges. Each sample is numbered from the request. The expected latency of the outcome is computed in the bench from these rules and compared with the sample number at which the pulse is seen. The bench checks both sides of the timeout boundary, and it checks that the pulse has gone one cycle later.

// File: rtl/bus_volt_seq.sv
module bus_volt_seq #(
  parameter int CLK_HZ     = 50_000_000,
  parameter int TIMEOUT_US = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [1:0] req_volt,
  input  logic       cap_3v3,
  input  logic       cap_1v8,
  input  logic       pwr_good,
  output logic [2:0] vsel,
  output logic       bus_pwr,
  output logic       lv_sig_en,
  output logic       busy,
  output logic       done,
  output logic       unsupported,
  output logic       timeout
);
  localparam int TMO   = (CLK_HZ / 1_000_000) * TIMEOUT_US;
  localparam int CNT_W = $clog2(TMO + 1);
  localparam logic [2:0] CODE_3V3 = 3'b111;
  localparam logic [2:0] CODE_1V8 = 3'b101;

  typedef enum logic [1:0] {S_IDLE, S_CODE, S_POLL} state_t;

  state_t           state;
  logic [CNT_W-1:0] cnt;
  logic             tgt_lo;

  wire want_hi = (req_volt == 2'b00);
  wire want_lo = (req_volt == 2'b01);
  wire ok      = (want_hi && cap_3v3) || (want_lo && cap_1v8);

  assign busy = (state != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      cnt         <= '0;
      tgt_lo      <= 1'b0;
      vsel        <= 3'b000;
      bus_pwr     <= 1'b0;
      lv_sig_en   <= 1'b0;
      done        <= 1'b0;
      unsupported <= 1'b0;
      timeout     <= 1'b0;
    end else begin
      done        <= 1'b0;
      unsupported <= 1'b0;
      timeout     <= 1'b0;
      case (state)
        S_IDLE:
          if (req_valid) begin
            if (ok) begin
              vsel    <= want_lo ? CODE_1V8 : CODE_3V3;
              tgt_lo  <= want_lo;
              bus_pwr <= 1'b0;
              state   <= S_CODE;
            end else begin
              unsupported <= 1'b1;
            end
          end
        S_CODE: begin
          bus_pwr <= 1'b1;
          cnt     <= '0;
          state   <= S_POLL;
        end
        S_POLL:
          if (pwr_good) begin
            done      <= 1'b1;
            lv_sig_en <= tgt_lo;
            state     <= S_IDLE;
          end else if (cnt == CNT_W'(TMO - 1)) begin
            timeout <= 1'b1;
            state   <= S_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_code_before_power_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_pwr) |-> $stable(vsel));

  assert_unsup_keeps_state_R2: assert property (@(posedge clk) disable iff (!rst_n)
    unsupported |-> ($stable(vsel) && $stable(lv_sig_en) && $stable(bus_pwr)));

  assert_done_after_good_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(pwr_good) && $past(bus_pwr)));

  assert_lv_moves_with_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lv_sig_en) |-> done);

  assert_timeout_powered_R7: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> ($past(bus_pwr) && !$past(pwr_good)));

  assert_single_outcome_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, unsupported, timeout}));

  assert_pulse_width_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done || unsupported || timeout) |=> !(done || unsupported || timeout));

  assert_idle_after_outcome_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done || timeout) |-> !busy);
endmodule

// File: tb/bus_volt_seq_tb.sv
module bus_volt_seq_tb;
  localparam int CLK_HZ     = 50_000_000;
  localparam int TIMEOUT_US = 20;
  localparam int TMO        = (CLK_HZ / 1_000_000) * TIMEOUT_US;
  localparam int NEVER      = 1_000_000;

  localparam int K_DONE = 0;
  localparam int K_UNS  = 1;
  localparam int K_TMO  = 2;

  typedef struct packed {
    logic [1:0]  volt;
    logic        c33;
    logic        c18;
    logic [31:0] dly;
    logic [1:0]  kind;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{2'b00, 1'b1, 1'b1, 32'd1,        2'd0},
    '{2'b01, 1'b1, 1'b1, 32'd5,        2'd0},
    '{2'b00, 1'b0, 1'b1, 32'd1,        2'd1},
    '{2'b01, 1'b1, 1'b0, 32'd1,        2'd1},
    '{2'b10, 1'b1, 1'b1, 32'd1,        2'd1},
    '{2'b11, 1'b1, 1'b1, 32'd1,        2'd1},
    '{2'b00, 1'b1, 1'b1, 32'd3,        2'd0},
    '{2'b01, 1'b1, 1'b1, NEVER,        2'd2},
    '{2'b01, 1'b1, 1'b1, TMO + 1,      2'd0},
    '{2'b00, 1'b1, 1'b1, TMO + 2,      2'd2},
    '{2'b00, 1'b1, 1'b1, 32'd2,        2'd0},
    '{2'b01, 1'b1, 1'b1, 32'd40,       2'd0}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [1:0] req_volt = 2'b00;
  logic       cap_3v3 = 1'b0;
  logic       cap_1v8 = 1'b0;
  logic       pwr_good = 1'b0;
  logic [2:0] vsel;
  logic       bus_pwr, lv_sig_en, busy, done, unsupported, timeout;

  int checks = 0;
  int errors = 0;
  logic [2:0] m_vsel = 3'b000;
  logic       m_lv   = 1'b0;

  always #10 clk = ~clk;

  bus_volt_seq #(.CLK_HZ(CLK_HZ), .TIMEOUT_US(TIMEOUT_US)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_volt(req_volt),
    .cap_3v3(cap_3v3), .cap_1v8(cap_1v8), .pwr_good(pwr_good),
    .vsel(vsel), .bus_pwr(bus_pwr), .lv_sig_en(lv_sig_en), .busy(busy),
    .done(done), .unsupported(unsupported), .timeout(timeout));

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int outcome();
    if (done) return K_DONE;
    if (unsupported) return K_UNS;
    if (timeout) return K_TMO;
    return -1;
  endfunction

  task automatic run_vec(input vec_t v);
    int exp_lat, got_lat, got_kind, d;
    logic accept;
    logic [2:0] code;
    d = int'(v.dly);
    accept = ((v.volt == 2'b00) && v.c33) || ((v.volt == 2'b01) && v.c18);
    code = (v.volt == 2'b01) ? 3'b101 : 3'b111;
    if (!accept) exp_lat = 1;
    else if (int'(v.kind) == K_TMO) exp_lat = TMO + 2;
    else exp_lat = ((d > 2) ? d : 2) + 1;
    req_volt = v.volt; cap_3v3 = v.c33; cap_1v8 = v.c18; req_valid = 1'b1;
    got_lat = -1; got_kind = -1;
    for (int n = 1; n <= TMO + 10; n++) begin
      @(negedge clk);
      if (n == 1) req_valid = 1'b0;
      if (n == d) pwr_good = 1'b1;
      if (accept && n == 1)
        chk(vsel == code && !bus_pwr && busy, "R4/R1 code before power", vsel, code);
      if (accept && n == 2)
        chk(bus_pwr == 1'b1, "R4 power after code", bus_pwr, 1);
      if (outcome() >= 0) begin
        got_lat = n; got_kind = outcome();
        break;
      end
    end
    pwr_good = 1'b0;
    chk(got_kind == int'(v.kind), "R2/R3/R5/R7 outcome kind", got_kind, v.kind);
    chk(got_lat == exp_lat, "R5/R7 outcome latency", got_lat, exp_lat);
    if (accept) m_vsel = code;
    if (accept && int'(v.kind) == K_DONE) m_lv = (v.volt == 2'b01);
    chk(vsel == m_vsel, "R1/R2 vsel after outcome", vsel, m_vsel);
    chk(lv_sig_en == m_lv, "R6 lv_sig_en after outcome", lv_sig_en, m_lv);
    @(negedge clk);
    chk(!done && !unsupported && !timeout && !busy, "R10 pulse one cycle",
        {done, unsupported, timeout, busy}, 0);
  endtask

  initial begin
    for (int c = 0; c < 150_000; c++) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", c_unused(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  function automatic int c_unused();
    return 1;
  endfunction

  initial begin
    int t;
    repeat (3) @(negedge clk);
    chk(vsel == 0 && !bus_pwr && !lv_sig_en && !busy && !done && !unsupported && !timeout,
        "R9 reset state", {vsel, bus_pwr, lv_sig_en, busy, done, unsupported, timeout}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R8: second request during a switch is ignored (last state: 1.8 V, lv=1)
    req_volt = 2'b00; cap_3v3 = 1'b1; cap_1v8 = 1'b1; req_valid = 1'b1;
    @(negedge clk);
    req_volt = 2'b01; req_valid = 1'b1;
    @(negedge clk);
    req_volt = 2'b10; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!unsupported && busy, "R8 request while busy ignored", unsupported, 0);
    chk(vsel == 3'b111, "R8 code not replaced", vsel, 3'b111);
    pwr_good = 1'b1;
    t = 0;
    for (int n = 0; n < 10; n++) begin
      @(negedge clk);
      if (done) begin t = n + 1; break; end
    end
    pwr_good = 1'b0;
    chk(t == 1, "R8 completes original request", t, 1);
    chk(vsel == 3'b111 && lv_sig_en == 1'b0, "R6 lv cleared on 3.3 V", lv_sig_en, 0);
    @(negedge clk);
    chk(!busy && !done, "R8 idle after outcome", busy, 0);

    // R2: refused request leaves power unchanged
    chk(bus_pwr == 1'b1, "R2 bus_pwr before refusal", bus_pwr, 1);
    cap_1v8 = 1'b0; req_volt = 2'b01; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(unsupported && bus_pwr && vsel == 3'b111 && !lv_sig_en,
        "R2 refusal keeps outputs", {unsupported, bus_pwr, vsel, lv_sig_en}, 6'b111110);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule